// File: doc/BRIEF.md
# Mixed-Precision Packed Integer Dot-Product Lane

This block is one 32-bit channel of a low-precision matrix engine. On each accepted cycle it receives a 32-bit word of packed weights, a 64-bit window of packed activations, a 4-bit precision code for each of the two operands, an element offset into the weight word and a 32-bit accumulator value. It unpacks sub-byte elements from both operands, each at its own width. It extends every element as signed or unsigned according to that operand's code. It multiplies the pairs, sums them, and adds the sum to the accumulator.

The two operands may use different precisions. The lane forms a 4-element dot product whenever either operand is 8 bits wide, and an 8-element dot product otherwise. A wide matrix engine places many of these lanes side by side. All lanes share the activation window, and each lane takes its own weight word and accumulator. The arithmetic is combinational. A parameter selects whether the result leaves through an output register or directly.

Top module: `mpDotLane`

## Requirements
- R1: Precision codes map as follows: 4'b0001 unsigned 1-bit, 4'b0010 signed 1-bit (-1..0), 4'b0011 unsigned 2-bit, 4'b0100 signed 2-bit (-2..1), 4'b0101 unsigned 4-bit, 4'b0110 signed 4-bit (-8..7), 4'b0111 unsigned 8-bit, 4'b1000 signed 8-bit (-128..127). Unsigned elements range from 0 to 2^bits-1. Signed elements are two's complement.
- R2: When either code is 4'b0111 or 4'b1000, exactly 4 element pairs (j = 0..3) are summed. Otherwise exactly 8 pairs (j = 0..7) are summed.
- R3: Weight element j occupies wgtWord bits starting at bit (elemOff + j) * weightBits, with its least significant bit lowest. Bit positions at or above 32 read as zero.
- R4: Activation element j occupies actWin bits starting at bit j * actBits, with its least significant bit lowest. Window bits that no element covers do not affect the result.
- R5: result equals accIn plus the signed sum of products, taken modulo 2^32 with no saturation.
- R6: If either code is 4'b0000 or lies in 4'b1001..4'b1111, the products contribute zero (result equals accIn) and codeErr is 1. With legal codes, codeErr is 0.
- R7: With REG_OUT=1, result, codeErr and outValid reflect the inputs of the cycle in which inValid was high, one clock edge later. With REG_OUT=0 they follow the inputs in the same cycle, and outValid equals inValid.
- R8: While rstN is low, the registered variant drives outValid, result and codeErr to 0.
- R9: With REG_OUT=1, a cycle with inValid low leaves result and codeErr unchanged and drives outValid low after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Inputs valid this cycle |
| wgtWord | input | 32 | Packed weight elements |
| actWin | input | 64 | Packed activation window |
| wgtCode | input | 4 | Weight precision code |
| actCode | input | 4 | Activation precision code |
| elemOff | input | 5 | Weight element offset, in weight elements |
| accIn | input | 32 | Accumulator input |
| outValid | output | 1 | Result valid |
| result | output | 32 | Accumulated result |
| codeErr | output | 1 | Unused or illegal precision code seen |

## Verification
The bench builds two copies of the lane. Instance u0 uses the default REG_OUT=1, which reaches the output register, the hold-on-idle behaviour and the reset values. A second copy uses REG_OUT=0 and exercises the same arithmetic with no latency, so each vector is compared on both paths. Both copies keep the 32-bit weight word and 64-bit window. These widths allow every width pairing, offsets that push weight elements past bit 31, and activation bits above those that any mode consumes.

// File: rtl/mpdot_pkg.sv
package mpdot_pkg;

  typedef struct packed {
    logic [3:0] wWidth;
    logic       wSigned;
    logic [3:0] aWidth;
    logic       aSigned;
    logic       useEight;
    logic       zeroOut;
  } laneCtl_t;

  function automatic logic [3:0] codeWidth(input logic [3:0] code);
    case (code)
      4'd1, 4'd2: codeWidth = 4'd1;
      4'd3, 4'd4: codeWidth = 4'd2;
      4'd5, 4'd6: codeWidth = 4'd4;
      4'd7, 4'd8: codeWidth = 4'd8;
      default:    codeWidth = 4'd0;
    endcase
  endfunction

  function automatic logic codeSigned(input logic [3:0] code);
    codeSigned = (code == 4'd2) || (code == 4'd4) || (code == 4'd6) || (code == 4'd8);
  endfunction

  function automatic logic codeLegal(input logic [3:0] code);
    codeLegal = (code >= 4'd1) && (code <= 4'd8);
  endfunction

endpackage

// File: rtl/mpdotCtrl.sv
module mpdotCtrl
  import mpdot_pkg::*;
(
  input  logic [3:0] wgtCode,
  input  logic [3:0] actCode,
  output laneCtl_t   ctl
);
  logic [3:0] wW, aW;

  always_comb begin
    wW = codeWidth(wgtCode);
    aW = codeWidth(actCode);
    ctl.wWidth   = wW;
    ctl.aWidth   = aW;
    ctl.wSigned  = codeSigned(wgtCode);
    ctl.aSigned  = codeSigned(actCode);
    ctl.useEight = !((wW == 4'd8) || (aW == 4'd8));
    ctl.zeroOut  = !(codeLegal(wgtCode) && codeLegal(actCode));
  end
endmodule

// File: rtl/mpdotElem.sv
module mpdotElem #(
  parameter int WORD_W  = 32,
  parameter int START_W = 10
) (
  input  logic [WORD_W-1:0]  word,
  input  logic [START_W-1:0] start,
  input  logic [3:0]         width,
  input  logic               isSigned,
  output logic signed [9:0]  val
);
  logic [WORD_W-1:0] shifted;
  logic [7:0]        mask, raw, topBit;
  logic [9:0]        wideRaw;

  always_comb begin
    shifted = word >> start;
    mask    = (8'd1 << width) - 8'd1;
    raw     = shifted[7:0] & mask;
    topBit  = 8'd1 << (width - 4'd1);
    wideRaw = {2'b00, raw};
    if (isSigned && ((raw & topBit) != 8'd0) && (width != 4'd0))
      val = $signed(wideRaw - ({2'b00, mask} + 10'd1));
    else
      val = $signed(wideRaw);
  end
endmodule

// File: rtl/mpdotPath.sv
module mpdotPath
  import mpdot_pkg::*;
#(
  parameter int WGT_W  = 32,
  parameter int ACT_W  = 64,
  parameter int ACC_W  = 32,
  parameter int MAX_EL = 8,
  parameter int OFF_W  = $clog2(WGT_W)
) (
  input  laneCtl_t         ctl,
  input  logic [WGT_W-1:0] wgtWord,
  input  logic [ACT_W-1:0] actWin,
  input  logic [OFF_W-1:0] elemOff,
  input  logic [ACC_W-1:0] accIn,
  output logic [ACC_W-1:0] sumOut
);
  localparam int START_W = $clog2((WGT_W + MAX_EL) * 8) + 1;
  localparam int PROD_W  = 20;
  localparam int SUM_W   = PROD_W + $clog2(MAX_EL) + 1;
  localparam int HALF_EL = MAX_EL / 2;

  logic signed [PROD_W-1:0] prod [MAX_EL];

  for (genvar j = 0; j < MAX_EL; j++) begin : g_el
    logic [START_W-1:0] wStart, aStart;
    logic signed [9:0]  wVal, aVal;
    logic               laneOn;

    assign wStart = (START_W'(elemOff) + START_W'(j)) * START_W'(ctl.wWidth);
    assign aStart = START_W'(j) * START_W'(ctl.aWidth);
    assign laneOn = (j < HALF_EL) || ctl.useEight;

    mpdotElem #(.WORD_W(WGT_W), .START_W(START_W)) u_w (
      .word(wgtWord), .start(wStart), .width(ctl.wWidth),
      .isSigned(ctl.wSigned), .val(wVal));
    mpdotElem #(.WORD_W(ACT_W), .START_W(START_W)) u_a (
      .word(actWin), .start(aStart), .width(ctl.aWidth),
      .isSigned(ctl.aSigned), .val(aVal));

    assign prod[j] = laneOn ? PROD_W'(wVal * aVal) : '0;
  end

  logic signed [SUM_W-1:0] dotSum;
  always_comb begin
    dotSum = '0;
    for (int j = 0; j < MAX_EL; j++) dotSum = dotSum + SUM_W'(prod[j]);
    if (ctl.zeroOut) dotSum = '0;
    sumOut = accIn + {{(ACC_W-SUM_W){dotSum[SUM_W-1]}}, dotSum};
  end
endmodule

// File: rtl/mpDotLane.sv
module mpDotLane
  import mpdot_pkg::*;
#(
  parameter int WGT_W   = 32,
  parameter int ACT_W   = 64,
  parameter int ACC_W   = 32,
  parameter int MAX_EL  = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [WGT_W-1:0]         wgtWord,
  input  logic [ACT_W-1:0]         actWin,
  input  logic [3:0]               wgtCode,
  input  logic [3:0]               actCode,
  input  logic [$clog2(WGT_W)-1:0] elemOff,
  input  logic [ACC_W-1:0]         accIn,
  output logic                     outValid,
  output logic [ACC_W-1:0]         result,
  output logic                     codeErr
);
  laneCtl_t         ctl;
  logic [ACC_W-1:0] sumNext;

  mpdotCtrl u_ctrl (.wgtCode(wgtCode), .actCode(actCode), .ctl(ctl));

  mpdotPath #(.WGT_W(WGT_W), .ACT_W(ACT_W), .ACC_W(ACC_W), .MAX_EL(MAX_EL)) u_path (
    .ctl(ctl), .wgtWord(wgtWord), .actWin(actWin), .elemOff(elemOff),
    .accIn(accIn), .sumOut(sumNext));

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outValid <= 1'b0;
        result   <= '0;
        codeErr  <= 1'b0;
      end else begin
        outValid <= inValid;
        if (inValid) begin
          result  <= sumNext;
          codeErr <= ctl.zeroOut;
        end
      end
    end
  end else begin : g_comb
    assign outValid = inValid;
    assign result   = sumNext;
    assign codeErr  = ctl.zeroOut;
  end
endmodule

// File: rtl/mpdotCheck.sv
module mpdotCheck #(
  parameter int ACC_W   = 32,
  parameter int WGT_W   = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [WGT_W-1:0] wgtWord,
  input logic [3:0]       wgtCode,
  input logic [3:0]       actCode,
  input logic [ACC_W-1:0] accIn,
  input logic             outValid,
  input logic [ACC_W-1:0] result,
  input logic             codeErr
);
  logic badCode;
  assign badCode = (wgtCode == 4'd0) || (wgtCode > 4'd8) || (actCode == 4'd0) || (actCode > 4'd8);

  if (REG_OUT) begin : g_seq
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid);
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> ($stable(result) && $stable(codeErr)));
    assert_bad_code_R6: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && badCode) |=> (codeErr && result == $past(accIn)));
    assert_good_code_R6: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !badCode) |=> !codeErr);
    assert_zero_weights_R5: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && !badCode && wgtWord == '0) |=> (result == $past(accIn)));
    always @(negedge clk) begin
      if (!rstN) begin
        assert_reset_values_R8: assert (!outValid && result == '0 && !codeErr);
      end
    end
  end else begin : g_cmb
    assert_valid_follows_R7: assert property (@(negedge clk) disable iff (!rstN)
      outValid == inValid);
    assert_bad_code_R6: assert property (@(negedge clk) disable iff (!rstN)
      badCode |-> (codeErr && result == accIn));
    assert_good_code_R6: assert property (@(negedge clk) disable iff (!rstN)
      !badCode |-> !codeErr);
    assert_zero_weights_R5: assert property (@(negedge clk) disable iff (!rstN)
      (!badCode && wgtWord == '0) |-> (result == accIn));
  end
endmodule

bind mpDotLane mpdotCheck #(.ACC_W(ACC_W), .WGT_W(WGT_W), .REG_OUT(REG_OUT)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .wgtWord(wgtWord),
  .wgtCode(wgtCode), .actCode(actCode), .accIn(accIn),
  .outValid(outValid), .result(result), .codeErr(codeErr));

// File: tb/sim_mpDotLane.sv
module sim_mpDotLane;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] wgtWord = '0;
  logic [63:0] actWin = '0;
  logic [3:0]  wgtCode = '0, actCode = '0;
  logic [4:0]  elemOff = '0;
  logic [31:0] accIn = '0;
  logic        vReg, eReg, vCmb, eCmb;
  logic [31:0] rReg, rCmb;
  int          errors = 0, checks = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  mpDotLane #(.REG_OUT(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wgtWord(wgtWord), .actWin(actWin),
    .wgtCode(wgtCode), .actCode(actCode), .elemOff(elemOff), .accIn(accIn),
    .outValid(vReg), .result(rReg), .codeErr(eReg));

  mpDotLane #(.REG_OUT(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .wgtWord(wgtWord), .actWin(actWin),
    .wgtCode(wgtCode), .actCode(actCode), .elemOff(elemOff), .accIn(accIn),
    .outValid(vCmb), .result(rCmb), .codeErr(eCmb));

  function automatic int widthOf(input logic [3:0] c);
    if (c == 4'd1 || c == 4'd2) return 1;
    if (c == 4'd3 || c == 4'd4) return 2;
    if (c == 4'd5 || c == 4'd6) return 4;
    if (c == 4'd7 || c == 4'd8) return 8;
    return 0;
  endfunction

  function automatic int fieldVal(input logic [63:0] src, input int lim, input int pos,
                                  input int w, input bit sgn);
    int v = 0;
    for (int b = 0; b < w; b++)
      if (pos + b < lim && src[pos + b]) v += (1 << b);
    if (sgn && w > 0 && v >= (1 << (w - 1))) v -= (1 << w);
    return v;
  endfunction

  function automatic logic [31:0] model(input logic [31:0] w, input logic [63:0] a,
      input logic [3:0] wc, input logic [3:0] ac, input int n, input logic [31:0] acc,
      output bit err);
    int ww = widthOf(wc), aw = widthOf(ac), cnt, s = 0;
    err = (ww == 0) || (aw == 0);
    if (err) return acc;
    cnt = (ww == 8 || aw == 8) ? 4 : 8;
    for (int k = 0; k < cnt; k++)
      s += fieldVal({32'd0, w}, 32, (n + k) * ww, ww, wc[0] == 1'b0)
         * fieldVal(a, 64, k * aw, aw, ac[0] == 1'b0);
    return acc + 32'(s);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runVec(input string req, input logic [31:0] w, input logic [63:0] a,
      input logic [3:0] wc, input logic [3:0] ac, input logic [4:0] n, input logic [31:0] acc);
    logic [31:0] exp;
    bit          err;
    exp = model(w, a, wc, ac, int'(n), acc, err);
    @(negedge clk);
    inValid = 1'b1; wgtWord = w; actWin = a; wgtCode = wc; actCode = ac; elemOff = n; accIn = acc;
    #1;
    check({req, " comb result R7"}, rCmb, exp);
    check({req, " comb err R6"}, {31'd0, eCmb}, {31'd0, err});
    @(negedge clk);
    check({req, " reg result R7"}, rReg, exp);
    check({req, " reg err R6"}, {31'd0, eReg}, {31'd0, err});
    check({req, " reg valid R7"}, {31'd0, vReg}, 32'd1);
    inValid = 1'b0;
  endtask

  task automatic testReset();
    check("R8 valid", {31'd0, vReg}, 32'd0);
    check("R8 result", rReg, 32'd0);
    check("R8 err", {31'd0, eReg}, 32'd0);
  endtask

  task automatic testEightBit();
    // R2: dot4 with s8 x s8: (-128*-128) + (127*-1) + (1*2) + (0*5) on acc 10
    runVec("R2 s8xs8", 32'h00_01_7F_80, 64'hFFFF_FFFF_05_02_FF_80, 4'd8, 4'd8, 5'd0, 32'd10);
    check("R2 s8xs8 value", rReg, 32'd16269);
    runVec("R2 u8xu4", 32'hFF_80_10_03, 64'h8765_4321, 4'd7, 4'd5, 5'd0, 32'd0);
  endtask

  task automatic testMixed();
    runVec("R1 u4xs4", 32'hFEDC_BA98, 64'h0123_89AB, 4'd5, 4'd6, 5'd0, 32'd100);
    runVec("R1 s2xu2", 32'hE4E4_E4E4, 64'h0000_1B1B, 4'd4, 4'd3, 5'd0, 32'd0);
    runVec("R1 s1xs1", 32'h0000_00FF, 64'h0000_00AA, 4'd2, 4'd2, 5'd0, 32'd7);
    // signed 1-bit: eight products of (-1)*(-1 or 0) = 4
    check("R1 s1 value", rReg, 32'd11);
    runVec("R1 u1xs8", 32'h0000_000F, 64'h80FF_7F01, 4'd1, 4'd8, 5'd0, 32'd0);
  endtask

  task automatic testOffset();
    runVec("R3 offset u4", 32'h1234_5678, 64'h1111_1111, 4'd5, 4'd5, 5'd3, 32'd0);
    // offset 6 u4: elements 6,7 real, 8..13 past bit 31 read as zero
    runVec("R3 past end", 32'hF100_0000, 64'h3333_3333, 4'd5, 4'd5, 5'd6, 32'd0);
    check("R3 past end value", rReg, 32'd48);
    runVec("R3 offset u1", 32'h8000_0001, 64'hFF, 4'd1, 4'd1, 5'd31, 32'd0);
    check("R3 offset u1 value", rReg, 32'd1);
  endtask

  task automatic testWindow();
    runVec("R4 upper bits low", 32'h0102_0304, 64'h0000_0000_0101_0101, 4'd7, 4'd7, 5'd0, 32'd0);
    runVec("R4 upper bits set", 32'h0102_0304, 64'hDEAD_BEEF_0101_0101, 4'd7, 4'd7, 5'd0, 32'd0);
    check("R4 upper ignored", rReg, 32'd10);
  endtask

  task automatic testWrap();
    runVec("R5 wrap", 32'h0000_007F, 64'h7F, 4'd8, 4'd8, 5'd0, 32'hFFFF_FFF0);
    check("R5 wrap value", rReg, 32'h0000_3EF1);
    runVec("R5 negative", 32'h0000_0080, 64'h7F, 4'd8, 4'd7, 5'd0, 32'd5);
  endtask

  task automatic testBadCodes();
    runVec("R6 unused w", 32'hFFFF_FFFF, 64'hFFFF, 4'd0, 4'd5, 5'd0, 32'h1234_5678);
    runVec("R6 illegal a", 32'hFFFF_FFFF, 64'hFFFF, 4'd5, 4'd12, 5'd0, 32'h0BAD_0BAD);
    check("R6 value", rReg, 32'h0BAD_0BAD);
  endtask

  task automatic testHold();
    logic [31:0] held;
    runVec("R9 setup", 32'h0303_0303, 64'h0202_0202, 4'd7, 4'd7, 5'd0, 32'd1);
    held = rReg;
    @(negedge clk);
    inValid = 1'b0; wgtWord = 32'hFFFF_FFFF; accIn = 32'h5555_5555; wgtCode = 4'd0;
    @(negedge clk);
    check("R9 held result", rReg, held);
    check("R9 held err", {31'd0, eReg}, 32'd0);
    check("R9 valid low", {31'd0, vReg}, 32'd0);
  endtask

  task automatic testSweep();
    for (int i = 0; i < 300; i++)
      runVec("R2 sweep", $urandom, {$urandom, $urandom}, 4'($urandom_range(0, 9)),
             4'($urandom_range(1, 8)), 5'($urandom), $urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testEightBit();
    testMixed();
    testOffset();
    testWindow();
    testWrap();
    testBadCodes();
    testHold();
    testSweep();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule